// File: doc/BRIEF.md
# Windowed Phase-Error Lock Detector

This block watches two single-cycle pulse streams that mark the reference-divider and feedback-divider edges of a PLL, both already sampled on a fast measurement clock. For each phase-detector cycle it pairs one reference pulse with one feedback pulse. It measures in measurement-clock cycles how far apart they are, and judges the pair either inside or outside a programmable window.

A single run counter counts consecutive in-window pairs and returns to zero on any out-of-window pair. Two thresholds read that one counter. The lock threshold drives a level flag that stays high while the run is long enough. The holdover threshold produces a single-cycle event when the run first steps onto it. A lock therefore cannot appear sooner than (lock threshold) phase-detector periods after the last error: a threshold of 10,000 at a 40 MHz comparison rate needs at least 250 µs. Any change to the configuration, or dropping the enable, restarts the run from zero.

Top module: `pll_lock_window_det`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are zero after that edge: counter 0, both verdict pulses low, lock flag low, holdover event low. Edge pulses arriving during reset have no effect.
- R2: When both pulses of a pair arrive in the same cycle, the phase error is 0. When the partner pulse arrives d cycles after the leading pulse, the error is d. A pair with error ≤ `win_cfg` raises `meas_ok` for one cycle after the edge on which the partner is sampled, and the counter is one higher on the following cycle.
- R3: When the partner has not arrived by `win_cfg` cycles after the leading pulse, `meas_bad` pulses one cycle after that edge. On the next cycle the counter is 0 and `lock_flag` is low, both changing on the same cycle.
- R4: `lock_flag` is high exactly when the counter is at or above the lock threshold. A threshold value of 0 acts as 1.
- R5: `hold_exit` pulses high for exactly one cycle, on the cycle the counter first steps from below the holdover threshold onto it. A threshold value of 0 acts as 1.
- R6: The 14-bit counter saturates at 16383 and does not wrap while in-window pairs continue.
- R7: A change of any of `win_cfg`, `lock_cfg` or `hold_cfg` clears the counter and the lock flag, and abandons any pair in progress.
- R8: While `en` is low, the counter stays at 0, no verdict pulses appear, and edges are ignored.
- R9: A second leading pulse that arrives before any partner gives an out-of-window verdict and starts a new measurement from the second pulse.
- R10: A partner pulse that arrives after its pair has already timed out is discarded and produces no verdict.
- R11: Either stream may lead a pair, and the measurement is symmetric in the two streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Detector enable; low holds the run at zero |
| win_cfg | input | 8 | Allowed phase error in measurement-clock cycles |
| lock_cfg | input | 14 | Run length at which the lock flag rises |
| hold_cfg | input | 14 | Run length that fires the holdover event |
| ref_edge | input | 1 | One-cycle pulse per reference-divider edge |
| fb_edge | input | 1 | One-cycle pulse per feedback-divider edge |
| meas_ok | output | 1 | One-cycle pulse: last pair was inside the window |
| meas_bad | output | 1 | One-cycle pulse: last pair was outside the window |
| run_count | output | 14 | Current count of consecutive in-window pairs |
| lock_flag | output | 1 | Lock detected |
| hold_exit | output | 1 | One-cycle holdover-exit event |

## Verification
The bench targets the window boundary on both sides, using errors equal to the window and one past it with either stream leading. An off-by-one timer would either accept the late pair or reject the on-edge one. It covers the partner that turns up after a timeout and the leading pulse that repeats before its partner. A detector that mishandled these would emit a phantom verdict or pair the wrong edges, and the run counter would drift. Zero-valued thresholds and a run long enough to reach saturation show whether the counter wraps and whether the holdover event refires or fires at all. Configuration changes and enable drops made while locked show whether the flag is left stuck high.

// File: rtl/lockdet_pkg.sv
// Shared types for the windowed lock detector.
package lockdet_pkg;

    // State of the edge-pairing timer.
    typedef enum logic [1:0] {
        PT_IDLE   = 2'd0,  // no pair open
        PT_WAIT   = 2'd1,  // leading edge seen, timing partner
        PT_ORPHAN = 2'd2   // pair timed out, late partner to be dropped
    } pair_state_e;

endpackage

// File: rtl/edge_pair_timer.sv
// Pairs reference and feedback pulses and judges each pair against a window.
// Assumes one-cycle input pulses; a pulse on both inputs in one cycle is an
// error of zero. Verdicts are registered and appear one cycle after the
// deciding edge. A flush returns the timer to idle without a verdict.
module edge_pair_timer
    import lockdet_pkg::*;
#(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             ref_edge,
    input  logic             fb_edge,
    input  logic [WIN_W-1:0] win,
    output logic             ok_pulse,
    output logic             bad_pulse
);

    localparam logic [WIN_W-1:0] TMR_ONE = {{(WIN_W-1){1'b0}}, 1'b1};

    pair_state_e      st_q, st_d;
    logic             lead_ref_q, lead_ref_d;
    logic [WIN_W-1:0] tmr_q, tmr_d;
    logic             ok_d, bad_d;
    logic             leader, partner, in_win;

    // Select the leading and partner streams for the open pair.
    always_comb begin
        leader  = lead_ref_q ? ref_edge : fb_edge;
        partner = lead_ref_q ? fb_edge  : ref_edge;
        in_win  = (tmr_q <= win);
    end

    // Next-state logic of the pairing timer and its verdict.
    always_comb begin
        st_d       = st_q;
        lead_ref_d = lead_ref_q;
        tmr_d      = tmr_q;
        ok_d       = 1'b0;
        bad_d      = 1'b0;
        if (flush) begin
            st_d  = PT_IDLE;
            tmr_d = '0;
        end else begin
            unique case (st_q)
                PT_IDLE: begin
                    if (ref_edge && fb_edge) begin
                        ok_d = 1'b1;
                    end else if (ref_edge || fb_edge) begin
                        st_d       = PT_WAIT;
                        lead_ref_d = ref_edge;
                        tmr_d      = TMR_ONE;
                    end
                end
                PT_WAIT: begin
                    if (partner) begin
                        ok_d  = in_win;
                        bad_d = !in_win;
                        if (leader) begin
                            tmr_d = TMR_ONE;
                        end else begin
                            st_d = PT_IDLE;
                        end
                    end else if (leader) begin
                        bad_d = 1'b1;
                        tmr_d = TMR_ONE;
                    end else if (tmr_q >= win) begin
                        bad_d = 1'b1;
                        st_d  = PT_ORPHAN;
                    end else begin
                        tmr_d = tmr_q + 1'b1;
                    end
                end
                PT_ORPHAN: begin
                    if (leader) begin
                        st_d  = PT_WAIT;
                        tmr_d = TMR_ONE;
                    end else if (partner) begin
                        st_d = PT_IDLE;
                    end
                end
                default: begin
                    st_d = PT_IDLE;
                end
            endcase
        end
    end

    // State, timer and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= PT_IDLE;
            lead_ref_q <= 1'b0;
            tmr_q      <= '0;
            ok_pulse   <= 1'b0;
            bad_pulse  <= 1'b0;
        end else begin
            st_q       <= st_d;
            lead_ref_q <= lead_ref_d;
            tmr_q      <= tmr_d;
            ok_pulse   <= ok_d;
            bad_pulse  <= bad_d;
        end
    end

endmodule

// File: rtl/run_counter.sv
// Saturating count of consecutive in-window verdicts.
// Clear has priority over step. Exposes the next value so that threshold
// logic can update on the same edge as the count.
module run_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_next
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Next value: clear, saturating increment, or hold.
    always_comb begin
        if (clear) begin
            count_next = '0;
        end else if (step && (count != CNT_MAX)) begin
            count_next = count + 1'b1;
        end else begin
            count_next = count;
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            count <= count_next;
        end
    end

endmodule

// File: rtl/lock_level_watch.sv
// Registered level flag: high while the run is at or above a threshold.
// Assumes a zero threshold means one. Updates on the same edge as the count.
module lock_level_watch #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_next,
    input  logic [CNT_W-1:0] thr,
    output logic             level
);

    logic [CNT_W-1:0] thr_eff;

    // Threshold with zero promoted to one.
    always_comb thr_eff = (thr == '0) ? CNT_W'(1) : thr;

    // Flag register tracking the next count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
        end else begin
            level <= (count_next >= thr_eff);
        end
    end

endmodule

// File: rtl/hold_event_watch.sv
// Registered one-cycle event when the run steps onto a threshold.
// Assumes the count moves by at most one per cycle, so "first reaches" means
// the next count equals the threshold while the current one does not.
module hold_event_watch #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] count_next,
    input  logic [CNT_W-1:0] thr,
    output logic             pulse
);

    logic [CNT_W-1:0] thr_eff;

    // Threshold with zero promoted to one.
    always_comb thr_eff = (thr == '0) ? CNT_W'(1) : thr;

    // Event register, high only on the arrival step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
        end else begin
            pulse <= (count_next == thr_eff) && (count != thr_eff);
        end
    end

endmodule

// File: rtl/cfg_change_detect.sv
// Flags any cycle whose configuration word differs from the previous cycle's.
// After reset the stored copy is zero, so a nonzero word flags once.
module cfg_change_detect #(
    parameter int CFG_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    output logic             changed
);

    logic [CFG_W-1:0] cfg_q;

    // Compare against last cycle's copy.
    always_comb changed = (cfg != cfg_q);

    // Keep last cycle's copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg;
        end
    end

endmodule

// File: rtl/pll_lock_window_det.sv
// Windowed lock detector top. One pair timer feeds one run counter, which
// two threshold watchers read: a level lock flag and a one-cycle holdover
// event. A disable or a configuration change flushes the timer and counter.
// Assumes the edge inputs are one-cycle pulses synchronous to clk.
module pll_lock_window_det #(
    parameter int WIN_W = 8,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIN_W-1:0] win_cfg,
    input  logic [CNT_W-1:0] lock_cfg,
    input  logic [CNT_W-1:0] hold_cfg,
    input  logic             ref_edge,
    input  logic             fb_edge,
    output logic             meas_ok,
    output logic             meas_bad,
    output logic [CNT_W-1:0] run_count,
    output logic             lock_flag,
    output logic             hold_exit
);

    localparam int CFG_W = WIN_W + 2 * CNT_W;

    logic             cfg_chg;
    logic             flush;
    logic [CNT_W-1:0] count_next;

    cfg_change_detect #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     ({win_cfg, lock_cfg, hold_cfg}),
        .changed (cfg_chg)
    );

    // Flush on disable or any configuration change.
    always_comb flush = !en || cfg_chg;

    edge_pair_timer #(.WIN_W(WIN_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .ref_edge  (ref_edge),
        .fb_edge   (fb_edge),
        .win       (win_cfg),
        .ok_pulse  (meas_ok),
        .bad_pulse (meas_bad)
    );

    run_counter #(.CNT_W(CNT_W)) u_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (flush || meas_bad),
        .step       (meas_ok),
        .count      (run_count),
        .count_next (count_next)
    );

    lock_level_watch #(.CNT_W(CNT_W)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_next (count_next),
        .thr        (lock_cfg),
        .level      (lock_flag)
    );

    hold_event_watch #(.CNT_W(CNT_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (run_count),
        .count_next (count_next),
        .thr        (hold_cfg),
        .pulse      (hold_exit)
    );

endmodule

// File: rtl/pll_lock_window_det_chk.sv
// Port-level checker for the lock detector, bound to every instance.
module pll_lock_window_det_chk #(
    parameter int WIN_W = 8,
    parameter int CNT_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [WIN_W-1:0] win_cfg,
    input logic [CNT_W-1:0] lock_cfg,
    input logic [CNT_W-1:0] hold_cfg,
    input logic             ref_edge,
    input logic             fb_edge,
    input logic             meas_ok,
    input logic             meas_bad,
    input logic [CNT_W-1:0] run_count,
    input logic             lock_flag,
    input logic             hold_exit
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    function automatic logic [CNT_W-1:0] eff(input logic [CNT_W-1:0] t);
        return (t == '0) ? CNT_W'(1) : t;
    endfunction

    // R1: reset leaves every output at zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (run_count == '0 && !meas_ok && !meas_bad && !lock_flag && !hold_exit));

    // R2 / R3: a pair has one verdict only.
    a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(meas_ok && meas_bad));

    // R2: an in-window verdict advances the run when nothing flushed it.
    a_r2_ok_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_ok && run_count != CNT_MAX) |=>
            (run_count == $past(run_count) + 1'b1) || !$past(en) ||
            ($past(win_cfg) != $past(win_cfg, 2)) ||
            ($past(lock_cfg) != $past(lock_cfg, 2)) ||
            ($past(hold_cfg) != $past(hold_cfg, 2)));

    // R3: an out-of-window verdict drops the run and the flag together.
    a_r3_bad_clears: assert property (@(posedge clk) disable iff (!rst_n)
        meas_bad |=> (run_count == '0 && !lock_flag));

    // R4: the flag agrees with the run against the threshold in force.
    a_r4_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        lock_flag == (run_count >= eff($past(lock_cfg))));

    // R5: the holdover event lasts one cycle.
    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        hold_exit |=> !hold_exit);

    // R5: the holdover event coincides with the run sitting on its threshold.
    a_r5_on_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_exit |-> (run_count == eff($past(hold_cfg))));

    // R6: at the ceiling the run either stays or is cleared, never wraps.
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_count == CNT_MAX) |=> (run_count == CNT_MAX || run_count == '0));

    // R8: disabled means idle on the next cycle.
    a_r8_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (run_count == '0 && !meas_ok && !meas_bad && !lock_flag && !hold_exit));

endmodule

bind pll_lock_window_det pll_lock_window_det_chk #(
    .WIN_W(WIN_W),
    .CNT_W(CNT_W)
) u_chk (.*);

// File: tb/tb_pll_lock_window_det.sv
module tb_pll_lock_window_det;

    localparam int WIN_W = 8;
    localparam int CNT_W = 14;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             en;
    logic [WIN_W-1:0] win_cfg;
    logic [CNT_W-1:0] lock_cfg;
    logic [CNT_W-1:0] hold_cfg;
    logic             ref_edge;
    logic             fb_edge;
    logic             meas_ok;
    logic             meas_bad;
    logic [CNT_W-1:0] run_count;
    logic             lock_flag;
    logic             hold_exit;

    always #5 clk = ~clk;

    pll_lock_window_det #(.WIN_W(WIN_W), .CNT_W(CNT_W)) dut (.*);

    typedef struct {
        int    cnt;
        bit    lock;
        bit    hold;
        bit    ok;
        string req;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   vectors = 0;
    int   miscompares = 0;
    int   n_results = 0;
    int   mcnt = 0;
    int   m_win = 0, m_lock = 0, m_hold = 0;
    bit   pend = 1'b0;
    bit   pend_ok = 1'b0;
    bit   done = 1'b0;

    function automatic int eff(int t);
        return (t == 0) ? 1 : t;
    endfunction

    task automatic chk_eq(string req, string what, int act, int expv);
        vectors++;
        if (act != expv) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    // Driver side of the scoreboard: model the run and queue the outcome.
    task automatic push(bit ok, string req);
        exp_t it;
        int prev = mcnt;
        mcnt = ok ? ((mcnt == MAXC) ? MAXC : mcnt + 1) : 0;
        it.cnt  = mcnt;
        it.ok   = ok;
        it.lock = (mcnt >= eff(m_lock));
        it.hold = ok && (mcnt == eff(m_hold)) && (prev < eff(m_hold));
        it.req  = req;
        q.push_back(it);
    endtask

    // One pair: leading pulse, partner d cycles later, then a one-cycle gap.
    task automatic pair(bit ref_first, int d, string req, bit expect_it = 1'b1);
        if (expect_it) push(d <= m_win, req);
        for (int k = 0; k <= d; k++) begin
            @(negedge clk);
            ref_edge = ref_first ? (k == 0) : (k == d);
            fb_edge  = ref_first ? (k == d) : (k == 0);
        end
        @(negedge clk);
        ref_edge = 1'b0;
        fb_edge  = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(int w, int l, int h, string req);
        @(negedge clk);
        win_cfg  = WIN_W'(w);
        lock_cfg = CNT_W'(l);
        hold_cfg = CNT_W'(h);
        m_win = w; m_lock = l; m_hold = h;
        mcnt = 0;
        repeat (2) @(negedge clk);
        chk_eq(req, "run_count after cfg change", int'(run_count), 0);
        chk_eq(req, "lock_flag after cfg change", int'(lock_flag), 0);
    endtask

    // Monitor side: a verdict seen now is compared against state one cycle on.
    always @(negedge clk) begin
        if (rst_n && pend) begin
            if (q.size() == 0) begin
                chk_eq("R10", "unexpected verdict count", 1, 0);
            end else begin
                e = q.pop_front();
                chk_eq(e.req, "verdict ok", int'(pend_ok), int'(e.ok));
                chk_eq(e.req, "run_count", int'(run_count), e.cnt);
                chk_eq(e.req, "lock_flag", int'(lock_flag), int'(e.lock));
                chk_eq(e.req, "hold_exit", int'(hold_exit), int'(e.hold));
            end
        end
        pend    = rst_n && (meas_ok || meas_bad);
        pend_ok = meas_ok;
        if (pend) n_results++;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL all requirements: watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        rst_n = 1'b0; en = 1'b1;
        win_cfg = '0; lock_cfg = '0; hold_cfg = '0;
        ref_edge = 1'b0; fb_edge = 1'b0;

        // R1: pulses during reset change nothing.
        @(negedge clk); ref_edge = 1'b1; fb_edge = 1'b1;
        @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b0;
        @(negedge clk);
        chk_eq("R1", "run_count in reset", int'(run_count), 0);
        chk_eq("R1", "meas_ok in reset", int'(meas_ok), 0);
        chk_eq("R1", "lock_flag in reset", int'(lock_flag), 0);
        chk_eq("R1", "hold_exit in reset", int'(hold_exit), 0);
        rst_n = 1'b1;

        // Window 4, lock at 5, holdover at 8.
        set_cfg(4, 5, 8, "R7");

        // R2 / R11: errors 0..4 with alternating leader, all inside.
        pair(1'b1, 0, "R2");
        pair(1'b0, 1, "R11");
        pair(1'b1, 2, "R2");
        pair(1'b0, 3, "R11");
        pair(1'b1, 4, "R4");
        chk_eq("R4", "lock_flag at threshold", int'(lock_flag), 1);
        pair(1'b0, 4, "R11");
        pair(1'b1, 0, "R2");
        pair(1'b1, 1, "R5");
        pair(1'b0, 0, "R5");

        // R3 / R10: one past the window, late partner must be dropped.
        base = n_results;
        pair(1'b1, 5, "R3");
        repeat (2) @(negedge clk);
        chk_eq("R10", "verdicts for timed-out pair", n_results - base, 1);
        chk_eq("R3", "lock_flag after miss", int'(lock_flag), 0);
        base = n_results;
        pair(1'b0, 7, "R10");
        repeat (2) @(negedge clk);
        chk_eq("R10", "verdicts for late reference", n_results - base, 1);

        // R9: leader repeats at +2, partner at +3 pairs with the second.
        push(1'b0, "R9");
        push(1'b1, "R9");
        for (int k = 0; k <= 3; k++) begin
            @(negedge clk);
            ref_edge = (k == 0) || (k == 2);
            fb_edge  = (k == 3);
        end
        @(negedge clk); ref_edge = 1'b0; fb_edge = 1'b0;
        repeat (3) @(negedge clk);
        chk_eq("R9", "run_count after restart", int'(run_count), 1);

        // R8: disabled, edges ignored.
        pair(1'b1, 0, "R8");
        @(negedge clk); en = 1'b0; mcnt = 0;
        base = n_results;
        pair(1'b1, 0, "R8", 1'b0);
        pair(1'b0, 2, "R8", 1'b0);
        chk_eq("R8", "run_count while disabled", int'(run_count), 0);
        chk_eq("R8", "verdicts while disabled", n_results - base, 0);
        en = 1'b1;
        repeat (2) @(negedge clk);
        pair(1'b1, 1, "R8");

        // R4 / R5: zero thresholds act as one; zero window takes only coincidence.
        set_cfg(0, 0, 0, "R7");
        pair(1'b1, 0, "R4");
        pair(1'b0, 1, "R3");
        pair(1'b1, 0, "R5");

        // R7: change while locked drops the flag.
        set_cfg(2, 2, 3, "R7");
        pair(1'b1, 2, "R4");
        pair(1'b0, 1, "R4");
        chk_eq("R4", "lock_flag before change", int'(lock_flag), 1);
        set_cfg(3, 2, 3, "R7");

        // R6: run past the ceiling.
        set_cfg(0, MAXC, MAXC, "R7");
        for (int i = 0; i < MAXC + 3; i++) pair(1'b1, 0, "R6");
        repeat (2) @(negedge clk);
        chk_eq("R6", "run_count saturated", int'(run_count), MAXC);
        chk_eq("R6", "lock_flag at ceiling", int'(lock_flag), 1);

        chk_eq("R2", "outstanding expected verdicts", q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule